// File: doc/BRIEF.md
# Register Interlock Issue Scoreboard

This unit decides, cycle by cycle, whether the next instruction of an in-order, single-issue pipeline may leave the issue stage. Every cycle it sees one decoded descriptor: a destination register with a write flag, three source register fields, each with a use bit and a late-use bit, a one-bit operation class (plain ALU or long multiply-accumulate) and a flag saying that the second operand is shifted by a register or uses rotate-with-extend. The descriptor is offered with a valid/ready handshake. The unit accepts it only when no source it reads is still waiting for a result and no earlier instruction still holds the issue slot.

For each architectural register the unit keeps a small count of the cycles left before a pending result can be consumed. An accepted instruction that writes a register loads that count with the latency of its class, and the new value replaces any older one. The late-use bit marks a source that is consumed as the value shifted by an immediate amount, or as the accumulating operand of a saturating doubling add or subtract. Such a source needs one more cycle. Each accepted instruction causes a one-cycle issue pulse carrying its sequence tag. A flush input clears all pending state.

Top module: `issue_interlock`

## Requirements
- R1: After reset the unit offers ready with no pending latency on any register, and the issue pulse is low.
- R2: A plain ALU operation (class 0, shift flag 0) holds the issue slot for one cycle. A consumer of its result that is not marked late-use can be accepted in the next cycle.
- R3: An ALU operation with the shift flag set holds the issue slot for two cycles, so ready is low in the cycle after acceptance. Its result can be consumed two cycles after acceptance.
- R4: A source with its late-use bit set becomes ready one cycle later than the same source without that bit, for every producer class.
- R5: A long multiply-accumulate (class 1) holds the issue slot for two cycles. An instruction that does not read its destination can be accepted two cycles after it.
- R6: An instruction reading the destination of a long multiply-accumulate, without the late-use bit, is accepted no earlier than five cycles after the multiply-accumulate.
- R7: Instructions are accepted strictly in order. An independent instruction behind a stalled one is accepted in the cycle after the stalled one, once it is offered.
- R8: A later write to a register replaces its pending latency, whether the new latency is shorter or longer than the old one.
- R9: Each accepted instruction gives issuePulse high in the next cycle, with issueTag equal to the accepted tag. In every other cycle issuePulse is low.
- R10: While flush is high, ready is low and nothing is accepted. In the next cycle all register latencies are clear.
- R11: Sources with the use bit at 0 are ignored, and an instruction with the destination write flag at 0 leaves every register latency unchanged.
- R12: A pending latency stalls only instructions that read that same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clears all pending latency and issue occupancy |
| inValid | input | 1 | Descriptor offered |
| inReady | output | 1 | Descriptor will be accepted this cycle if valid |
| inTag | input | TAG_W | Sequence tag of the descriptor |
| inOpClass | input | 1 | 0 plain ALU, 1 long multiply-accumulate |
| inShiftReg | input | 1 | ALU second operand shifted by register or rotate-with-extend |
| inDestWe | input | 1 | Instruction writes inDest |
| inDest | input | REG_W | Destination register |
| inSrc | input | NUM_SRC*REG_W | Source registers, slot k in bits k*REG_W upward |
| inSrcUse | input | NUM_SRC | Source slot k is read |
| inSrcLate | input | NUM_SRC | Source slot k is consumed late (one extra cycle) |
| issuePulse | output | 1 | An instruction was accepted in the previous cycle |
| issueTag | output | TAG_W | Tag of that instruction |

## Verification
A wrong per-register count shows up at inReady. A consumer placed at a chosen distance after its producer is then accepted one or more cycles too early or too late, so the bench sweeps every producer class, both usage kinds, every source slot and gaps of zero to seven idle cycles, and compares the acceptance cycle against max(issue latency, result latency plus late bit). A count written to the wrong register appears as a stall on an independent register, or as no stall at all, within the first cycle the consumer is offered. A wrong occupancy count appears as ready in the cycle directly after a two-slot instruction. A lost or delayed issue pulse shows up one cycle after acceptance.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  parameter int NUM_REGS = 16;
  parameter int REG_W    = $clog2(NUM_REGS);
  parameter int NUM_SRC  = 3;
  parameter int CNT_W    = 3;  // latencies up to 2**CNT_W-1
  parameter int TAG_W    = 8;

  typedef enum logic {
    OP_ALU  = 1'b0,
    OP_LMAC = 1'b1
  } opClass_e;

  // strobes from control to latency datapath
  typedef struct packed {
    logic             clear;
    logic             load;
    logic [REG_W-1:0] dest;
    logic [CNT_W-1:0] lat;
  } ilkStrobe_t;
endpackage

// File: rtl/ilk_latency.sv
module ilk_latency
  import ilk_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ilkStrobe_t               strobe,
  input  logic [NUM_SRC*REG_W-1:0] srcRegs,
  input  logic [NUM_SRC-1:0]       srcUse,
  input  logic [NUM_SRC-1:0]       srcLate,
  output logic                     srcBlocked
);
  logic [CNT_W-1:0] cntArr [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [CNT_W-1:0] cntQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                      cntQ <= '0;
      else if (strobe.clear)                          cntQ <= '0;
      else if (strobe.load && strobe.dest == REG_W'(r)) cntQ <= strobe.lat;
      else if (cntQ != '0)                            cntQ <= cntQ - 1'b1;
    end
    assign cntArr[r] = cntQ;
  end

  // normal use ready at count <= 1, late use at count == 0
  always_comb begin
    srcBlocked = 1'b0;
    for (int j = 0; j < NUM_SRC; j++) begin
      logic [CNT_W-1:0] c;
      c = cntArr[srcRegs[j*REG_W +: REG_W]];
      if (srcUse[j]) begin
        if (srcLate[j]) srcBlocked = srcBlocked | (c != '0);
        else            srcBlocked = srcBlocked | (c > CNT_W'(1));
      end
    end
  end
endmodule

// File: rtl/ilk_ctrl.sv
module ilk_ctrl
  import ilk_pkg::*;
#(
  parameter int ALU_ISS = 1,
  parameter int SHR_ISS = 2,
  parameter int MAC_ISS = 2,
  parameter int ALU_RES = 1,
  parameter int SHR_RES = 2,
  parameter int MAC_RES = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inValid,
  input  logic             srcBlocked,
  input  opClass_e         opClass,
  input  logic             shiftReg,
  input  logic             destWe,
  input  logic [REG_W-1:0] dest,
  input  logic [TAG_W-1:0] tag,
  output logic             ready,
  output ilkStrobe_t       strobe,
  output logic             issuePulse,
  output logic [TAG_W-1:0] issueTag
);
  logic [CNT_W-1:0] occCnt;
  logic [CNT_W-1:0] issLat;
  logic [CNT_W-1:0] resLat;
  logic             accept;

  always_comb begin
    if (opClass == OP_LMAC) begin
      issLat = CNT_W'(MAC_ISS);
      resLat = CNT_W'(MAC_RES);
    end else if (shiftReg) begin
      issLat = CNT_W'(SHR_ISS);
      resLat = CNT_W'(SHR_RES);
    end else begin
      issLat = CNT_W'(ALU_ISS);
      resLat = CNT_W'(ALU_RES);
    end
  end

  assign ready  = !flush && (occCnt == '0) && !srcBlocked;
  assign accept = inValid && ready;

  always_comb begin
    strobe.clear = flush;
    strobe.load  = accept && destWe;
    strobe.dest  = dest;
    strobe.lat   = resLat;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          occCnt <= '0;
    else if (flush)     occCnt <= '0;
    else if (accept)    occCnt <= issLat - 1'b1;
    else if (occCnt != '0) occCnt <= occCnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issuePulse <= 1'b0;
      issueTag   <= '0;
    end else begin
      issuePulse <= accept;
      if (accept) issueTag <= tag;
    end
  end
endmodule

// File: rtl/issue_interlock.sv
module issue_interlock
  import ilk_pkg::*;
#(
  parameter int ALU_ISS = 1,
  parameter int SHR_ISS = 2,
  parameter int MAC_ISS = 2,
  parameter int ALU_RES = 1,
  parameter int SHR_RES = 2,
  parameter int MAC_RES = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic [TAG_W-1:0]         inTag,
  input  logic                     inOpClass,
  input  logic                     inShiftReg,
  input  logic                     inDestWe,
  input  logic [REG_W-1:0]         inDest,
  input  logic [NUM_SRC*REG_W-1:0] inSrc,
  input  logic [NUM_SRC-1:0]       inSrcUse,
  input  logic [NUM_SRC-1:0]       inSrcLate,
  output logic                     issuePulse,
  output logic [TAG_W-1:0]         issueTag
);
  ilkStrobe_t strobe;
  logic       srcBlocked;

  ilk_ctrl #(
    .ALU_ISS(ALU_ISS), .SHR_ISS(SHR_ISS), .MAC_ISS(MAC_ISS),
    .ALU_RES(ALU_RES), .SHR_RES(SHR_RES), .MAC_RES(MAC_RES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .flush      (flush),
    .inValid    (inValid),
    .srcBlocked (srcBlocked),
    .opClass    (opClass_e'(inOpClass)),
    .shiftReg   (inShiftReg),
    .destWe     (inDestWe),
    .dest       (inDest),
    .tag        (inTag),
    .ready      (inReady),
    .strobe     (strobe),
    .issuePulse (issuePulse),
    .issueTag   (issueTag)
  );

  ilk_latency u_lat (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .srcRegs    (inSrc),
    .srcUse     (inSrcUse),
    .srcLate    (inSrcLate),
    .srcBlocked (srcBlocked)
  );
endmodule

// File: rtl/ilk_checker.sv
module ilk_checker
  import ilk_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             flush,
  input logic             inValid,
  input logic             inReady,
  input logic [TAG_W-1:0] inTag,
  input logic             inOpClass,
  input logic             inShiftReg,
  input logic             inDestWe,
  input logic [REG_W-1:0] inDest,
  input logic [REG_W-1:0] src0,
  input logic             src0Use,
  input logic             issuePulse,
  input logic [TAG_W-1:0] issueTag
);
  logic acc;
  assign acc = inValid && inReady;

  AST_PULSE_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    acc |=> (issuePulse && issueTag == $past(inTag))); // R9
  AST_NO_SPURIOUS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !acc |=> !issuePulse); // R9
  AST_MAC_HOLDS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (acc && inOpClass) |=> !inReady); // R5
  AST_SHIFT_HOLDS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (acc && !inOpClass && inShiftReg) |=> !inReady); // R3
  AST_FLUSH_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !issuePulse); // R10
  AST_MAC_DEP_STALL: assert property (@(posedge clk) disable iff (!rstN || flush)
    (acc && inOpClass && inDestWe) |=> ##1
    (!(inValid && src0Use && src0 == $past(inDest, 2)) || !inReady)); // R6
endmodule

bind issue_interlock ilk_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .flush      (flush),
  .inValid    (inValid),
  .inReady    (inReady),
  .inTag      (inTag),
  .inOpClass  (inOpClass),
  .inShiftReg (inShiftReg),
  .inDestWe   (inDestWe),
  .inDest     (inDest),
  .src0       (inSrc[ilk_pkg::REG_W-1:0]),
  .src0Use    (inSrcUse[0]),
  .issuePulse (issuePulse),
  .issueTag   (issueTag)
);

// File: tb/issue_interlock_tb.sv
module issue_interlock_tb;
  import ilk_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [TAG_W-1:0] inTag = '0;
  logic inOpClass = 1'b0;
  logic inShiftReg = 1'b0;
  logic inDestWe = 1'b0;
  logic [REG_W-1:0] inDest = '0;
  logic [NUM_SRC*REG_W-1:0] inSrc = '0;
  logic [NUM_SRC-1:0] inSrcUse = '0;
  logic [NUM_SRC-1:0] inSrcLate = '0;
  logic issuePulse;
  logic [TAG_W-1:0] issueTag;

  int nChecks = 0;
  int nFails = 0;
  int tagCnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  issue_interlock u_dut (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
    .inTag(inTag), .inOpClass(inOpClass), .inShiftReg(inShiftReg), .inDestWe(inDestWe),
    .inDest(inDest), .inSrc(inSrc), .inSrcUse(inSrcUse), .inSrcLate(inSrcLate),
    .issuePulse(issuePulse), .issueTag(issueTag)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns cycles waited before acceptance
  task automatic send(input bit mac, input bit shr, input bit we, input int dest,
                      input int s0, input int s1, input int s2,
                      input logic [2:0] use3, input logic [2:0] late3, output int w);
    logic [TAG_W-1:0] myTag;
    tagCnt++;
    myTag = TAG_W'(tagCnt);
    inTag = myTag; inOpClass = mac; inShiftReg = shr; inDestWe = we;
    inDest = REG_W'(dest);
    inSrc = {REG_W'(s2), REG_W'(s1), REG_W'(s0)};
    inSrcUse = use3; inSrcLate = late3; inValid = 1'b1;
    w = 0;
    #1;
    while (!inReady && w < 64) begin
      @(negedge clk); w++; #1;
    end
    if (w >= 64) check(0, "R7 hang", w, 0);
    @(negedge clk);
    check(issuePulse && issueTag == myTag, "R9 pulse/tag", int'(issueTag), int'(myTag));
    inValid = 1'b0; inSrcUse = '0; inDestWe = 1'b0; inSrcLate = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int w;
    idle(2);
    rstN = 1'b1;
    @(negedge clk); #1;
    check(inReady == 1'b1, "R1 ready after reset", inReady, 1);
    check(issuePulse == 1'b0, "R1 pulse low after reset", issuePulse, 0);
    @(negedge clk);
    send(0, 0, 0, 0, 3, 9, 15, 3'b111, 3'b111, w);
    check(w == 0, "R1 no pending latency", w, 0);
    idle(8);

    // sweep producer class x late bit x gap, dependent slot rotating
    for (int p = 0; p < 3; p++) begin
      for (int l = 0; l < 2; l++) begin
        for (int g = 0; g < 8; g++) begin
          int iss, res, slot, dst, rdy, exp;
          int s[3];
          string tagName;
          iss  = (p == 0) ? 1 : 2;
          res  = (p == 0) ? 1 : (p == 1) ? 2 : 5;
          slot = (p * 16 + l * 8 + g) % 3;
          dst  = (p * 5 + g) % 16;
          s[0] = (dst + 3) % 16; s[1] = (dst + 7) % 16; s[2] = (dst + 11) % 16;
          s[slot] = dst;
          send(p == 2, p == 1, 1, dst, 0, 0, 0, 3'b000, 3'b000, w);
          idle(g);
          send(0, 0, 0, 0, s[0], s[1], s[2], 3'b111, l ? 3'(1 << slot) : 3'b000, w);
          rdy = (iss > res + l) ? iss : res + l;
          exp = (rdy - (1 + g) > 0) ? rdy - (1 + g) : 0;
          tagName = (p == 0) ? "R2" : (p == 1) ? "R3" : "R6";
          if (l) tagName = {tagName, "/R4 late"};
          check(w == exp, tagName, w, exp);
          idle(8);
        end
      end
    end

    // R5: independent instruction behind long MAC
    send(1, 0, 1, 1, 0, 0, 0, 3'b000, 3'b000, w);
    send(0, 0, 0, 0, 2, 4, 6, 3'b111, 3'b000, w);
    check(w == 1, "R5 independent after MAC", w, 1);
    idle(8);

    // R11: unused source on pending register is ignored
    send(1, 0, 1, 3, 0, 0, 0, 3'b000, 3'b000, w);
    send(0, 0, 0, 0, 3, 3, 3, 3'b000, 3'b000, w);
    check(w == 1, "R11 unused source", w, 1);
    idle(8);
    // R11: no destination write loads nothing
    send(1, 0, 0, 4, 0, 0, 0, 3'b000, 3'b000, w);
    send(0, 0, 0, 0, 4, 0, 0, 3'b001, 3'b001, w);
    check(w == 1, "R11 no write", w, 1);
    idle(8);

    // R12: pending latency on r5 does not block r6
    send(1, 0, 1, 5, 0, 0, 0, 3'b000, 3'b000, w);
    idle(1);
    send(0, 0, 0, 0, 6, 6, 6, 3'b111, 3'b000, w);
    check(w == 0, "R12 other register", w, 0);
    idle(8);

    // R8: shorter overwrite
    send(1, 0, 1, 7, 0, 0, 0, 3'b000, 3'b000, w);
    send(0, 0, 1, 7, 0, 0, 0, 3'b000, 3'b000, w);
    check(w == 1, "R8 overwrite issue", w, 1);
    send(0, 0, 0, 0, 0, 7, 0, 3'b010, 3'b000, w);
    check(w == 0, "R8 shorter overwrite", w, 0);
    idle(8);
    // R8: longer overwrite
    send(0, 0, 1, 8, 0, 0, 0, 3'b000, 3'b000, w);
    send(1, 0, 1, 8, 0, 0, 0, 3'b000, 3'b000, w);
    check(w == 0, "R8 MAC after ALU", w, 0);
    send(0, 0, 0, 0, 0, 0, 8, 3'b100, 3'b000, w);
    check(w == 4, "R8 longer overwrite", w, 4);
    idle(8);

    // R7: in-order behind stalled dependent
    send(1, 0, 1, 1, 0, 0, 0, 3'b000, 3'b000, w);
    send(0, 0, 1, 2, 1, 0, 0, 3'b001, 3'b000, w);
    check(w == 4, "R7 stalled dependent", w, 4);
    send(0, 0, 1, 9, 10, 0, 0, 3'b001, 3'b000, w);
    check(w == 0, "R7 follower next cycle", w, 0);
    idle(8);

    // R10: flush clears pending latency
    send(1, 0, 1, 2, 0, 0, 0, 3'b000, 3'b000, w);
    flush = 1'b1;
    inTag = 8'hEE; inOpClass = 0; inShiftReg = 0; inDestWe = 0;
    inSrc = {REG_W'(0), REG_W'(0), REG_W'(9)}; inSrcUse = 3'b001; inValid = 1'b1;
    #1;
    check(inReady == 1'b0, "R10 ready low in flush", inReady, 0);
    @(negedge clk);
    flush = 1'b0; inValid = 1'b0; inSrcUse = '0;
    check(issuePulse == 1'b0, "R10 no accept in flush", issuePulse, 0);
    send(0, 0, 0, 0, 2, 0, 0, 3'b001, 3'b001, w);
    check(w == 0, "R10 latency cleared", w, 0);
    idle(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFails);
    $finish;
  end
endmodule